// File: doc/BRIEF.md
# Serial Register Access Frame Master

This block sits on the host side of an asynchronous serial link to a metering device and runs one register transaction at a time. A command port supplies a 7-bit register address, a write flag, 16 bits of write data and a start strobe. The block builds the request frame and shifts it out through its own UART transmitter. For a read, it then listens for a fixed window, assembles the returned data bytes and checks the trailing checksum.

Frames open with the constant byte 0xA5 and an address byte. A write frame carries one or two data bytes, depending on the value, and ends with a checksum. A read request carries neither data nor a checksum. When a transaction ends, the block pulses `doneO` for one cycle and holds the read data and the three status flags until the next transaction ends.

Top module: `regfrm_master`

## Requirements
- R1: Every request starts with byte 0xA5 followed by one address byte; a read request is exactly these two bytes.
- R2: The address byte of a write has bit 7 set (`{1'b1, addrI}`); the address byte of a read has bit 7 clear (`{1'b0, addrI}`).
- R3: A write value below 0x00FF is sent as one data byte (its low byte); any other value, 0x00FF included, is sent as two bytes, high byte first.
- R4: A write frame ends with a checksum byte equal to the bitwise inverse of the 8-bit wrapping sum of 0xA5, the address byte and the data bytes sent.
- R5: Each byte on `txO` is one start bit (0), eight data bits LSB first, an even parity bit and one stop bit (1), each lasting CLKS_PER_BIT clocks; the line idles high.
- R6: A read expects N data bytes, MSB first, followed by one checksum byte. `rdataO` holds the data bytes right-justified. `errO` is set when the checksum byte differs from the inverse of the 8-bit sum of 0xA5, the address byte and the N data bytes.
- R7: `rdLenI` values 2 and 3 select N = 2 and N = 3; every other value selects N = 4.
- R8: The receive window opens when the last stop bit of the read request ends and lasts WINDOW_CYCLES clocks. If no byte arrives in it, `rdataO` is 0, `timeoutO` is 1 and `errO` is 0.
- R9: If more than N+1 bytes arrive in the window, `overrunO` is 1.
- R10: A parity error or a missing stop bit on any received byte sets `errO`. `errO` is also set when fewer than N+1 bytes arrive, provided at least one byte arrived.
- R11: `startI` is accepted only while `busyO` is low; a strobe while busy changes neither the frame being sent nor the result. `busyO` rises only after an accepted strobe.
- R12: `doneO` is high for exactly one clock per transaction, with `busyO` low in that cycle. The results change only in that cycle. A write ends with `rdataO` = 0 and all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start strobe for one transaction |
| wrI | input | 1 | 1 = register write, 0 = register read |
| addrI | input | 7 | Register address |
| wdataI | input | 16 | Write value |
| rdLenI | input | 3 | Expected read data byte count (2, 3, otherwise 4) |
| rxI | input | 1 | Serial line from the device |
| txO | output | 1 | Serial line to the device |
| busyO | output | 1 | Transaction in progress |
| doneO | output | 1 | One-clock end-of-transaction pulse |
| rdataO | output | 32 | Assembled read data |
| errO | output | 1 | Checksum, parity, stop-bit or short-response error |
| timeoutO | output | 1 | No response byte arrived in the window |
| overrunO | output | 1 | More response bytes than expected |

## Verification
Request byte k starts its period of 11·CLKS_PER_BIT+2 clocks one clock after the accepted start edge. A write of n bytes therefore raises `doneO` n·(11·CLKS_PER_BIT+2)+1 edges after that start edge. A read raises it 2·(11·CLKS_PER_BIT+2)+WINDOW_CYCLES+1 edges after that start edge, whatever arrives on `rxI`. The bench counts rising edges from the start strobe, checks that the count matches these formulas exactly, and reads the results on the falling edge where `doneO` is high. One falling edge later it confirms that `doneO` has dropped. Request bytes are decoded from `txO` at mid-bit on falling edges. Response bytes are driven onto `rxI` only after the second request byte has been seen, and they finish well inside the window.

// File: rtl/regfrm_pkg.sv
package regfrm_pkg;

  typedef struct packed {
    logic load;
    logic sendByte;
    logic openWin;
    logic finish;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAITTX, ST_LISTEN, ST_FIN
  } ctlState_t;

  localparam logic [7:0] HEADER_BYTE = 8'hA5;

  function automatic logic [2:0] effLen(input logic [2:0] req);
    return (req == 3'd2 || req == 3'd3) ? req : 3'd4;
  endfunction

endpackage

// File: rtl/regfrm_uart_tx.sv
module regfrm_uart_tx #(
  parameter int CLKS_PER_BIT = 1302
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic [7:0] byteI,
  output logic       busyO,
  output logic       txO
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);

  logic [10:0]      shReg;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitNum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      cnt    <= '0;
      bitNum <= '0;
      busyO  <= 1'b0;
    end else if (startI && !busyO) begin
      shReg  <= {1'b1, ^byteI, byteI, 1'b0};
      cnt    <= '0;
      bitNum <= '0;
      busyO  <= 1'b1;
    end else if (busyO) begin
      if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
        cnt <= '0;
        if (bitNum == 4'd10) begin
          busyO <= 1'b0;
        end else begin
          bitNum <= bitNum + 4'd1;
          shReg  <= {1'b1, shReg[10:1]};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign txO = busyO ? shReg[0] : 1'b1;
endmodule

// File: rtl/regfrm_uart_rx.sv
module regfrm_uart_rx #(
  parameter int CLKS_PER_BIT = 1302
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxI,
  output logic       validO,
  output logic [7:0] byteO,
  output logic       badO
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF  = CLKS_PER_BIT / 2;

  logic [1:0]       syncReg;
  logic             line;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bitNum;
  logic [7:0]       shReg;
  logic             parBit;

  assign line = syncReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= 2'b11;
      active  <= 1'b0;
      cnt     <= '0;
      bitNum  <= '0;
      shReg   <= '0;
      parBit  <= 1'b0;
      validO  <= 1'b0;
      byteO   <= '0;
      badO    <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], rxI};
      validO  <= 1'b0;
      if (!active) begin
        if (!line) begin
          active <= 1'b1;
          cnt    <= '0;
          bitNum <= '0;
        end
      end else if (bitNum == 4'd0) begin
        if (cnt == CNT_W'(HALF - 1)) begin
          cnt <= '0;
          if (line) active <= 1'b0;
          else      bitNum <= 4'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
        cnt    <= '0;
        bitNum <= bitNum + 4'd1;
        if (bitNum <= 4'd8) begin
          shReg <= {line, shReg[7:1]};
        end else if (bitNum == 4'd9) begin
          parBit <= line;
        end else begin
          active <= 1'b0;
          validO <= 1'b1;
          byteO  <= shReg;
          badO   <= (parBit != ^shReg) || !line;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/regfrm_datapath.sv
module regfrm_datapath
  import regfrm_pkg::*;
#(
  parameter int CLKS_PER_BIT  = 1302,
  parameter int WINDOW_CYCLES = 150000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  ctl,
  input  logic        wrI,
  input  logic [6:0]  addrI,
  input  logic [15:0] wdataI,
  input  logic [2:0]  rdLenI,
  input  logic        rxI,
  output logic        txO,
  output logic        txBusyO,
  output logic        lastByteO,
  output logic        winDoneO,
  output logic        isWrO,
  output logic [31:0] rdataO,
  output logic        errO,
  output logic        timeoutO,
  output logic        overrunO,
  output logic        doneO
);
  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);

  logic [7:0]       addrByte, curByte, txSum, sumAcc, ckByte;
  logic [15:0]      wdata;
  logic [2:0]       rdLen, txIdx, txTotal, rxCnt;
  logic             twoData, winOpen, badSeen;
  logic [WIN_W-1:0] winCnt;
  logic [31:0]      dataAcc;
  logic             rxValid, rxBad;
  logic [7:0]       rxByte;

  assign twoData   = (wdata >= 16'h00FF);
  assign txTotal   = isWrO ? (twoData ? 3'd5 : 3'd4) : 3'd2;
  assign lastByteO = (txIdx == txTotal);
  assign winDoneO  = winOpen && (winCnt == '0);
  assign txSum     = HEADER_BYTE + addrByte + wdata[15:8] + wdata[7:0];

  always_comb begin
    unique case (txIdx)
      3'd0:    curByte = HEADER_BYTE;
      3'd1:    curByte = addrByte;
      3'd2:    curByte = twoData ? wdata[15:8] : wdata[7:0];
      3'd3:    curByte = twoData ? wdata[7:0] : ~txSum;
      default: curByte = ~txSum;
    endcase
  end

  regfrm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) txU (
    .clk(clk), .rstN(rstN), .startI(ctl.sendByte), .byteI(curByte),
    .busyO(txBusyO), .txO(txO));

  regfrm_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rxU (
    .clk(clk), .rstN(rstN), .rxI(rxI),
    .validO(rxValid), .byteO(rxByte), .badO(rxBad));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWrO <= 1'b0; addrByte <= '0; wdata <= '0; rdLen <= 3'd4; txIdx <= '0;
      winOpen <= 1'b0; winCnt <= '0; rxCnt <= '0; dataAcc <= '0;
      sumAcc <= '0; ckByte <= '0; badSeen <= 1'b0;
      rdataO <= '0; errO <= 1'b0; timeoutO <= 1'b0; overrunO <= 1'b0; doneO <= 1'b0;
    end else begin
      doneO <= ctl.finish;
      if (ctl.load) begin
        isWrO    <= wrI;
        addrByte <= {wrI, addrI};
        wdata    <= wdataI;
        rdLen    <= effLen(rdLenI);
        txIdx    <= '0;
      end
      if (ctl.sendByte) txIdx <= txIdx + 3'd1;
      if (ctl.openWin) begin
        winOpen <= 1'b1;
        winCnt  <= WIN_W'(WINDOW_CYCLES - 1);
        rxCnt   <= '0;
        dataAcc <= '0;
        sumAcc  <= HEADER_BYTE + addrByte;
        ckByte  <= '0;
        badSeen <= 1'b0;
      end else if (winOpen) begin
        if (winCnt == '0) winOpen <= 1'b0;
        else              winCnt  <= winCnt - 1'b1;
        if (rxValid) begin
          if (rxCnt != 3'd7) rxCnt <= rxCnt + 3'd1;
          if (rxBad) badSeen <= 1'b1;
          if (rxCnt < rdLen) begin
            dataAcc <= {dataAcc[23:0], rxByte};
            sumAcc  <= sumAcc + rxByte;
          end else if (rxCnt == rdLen) begin
            ckByte <= rxByte;
          end
        end
      end
      if (ctl.finish) begin
        if (isWrO || rxCnt == '0) begin
          rdataO   <= '0;
          errO     <= 1'b0;
          timeoutO <= !isWrO;
          overrunO <= 1'b0;
        end else begin
          rdataO   <= dataAcc;
          timeoutO <= 1'b0;
          overrunO <= ({1'b0, rxCnt} > ({1'b0, rdLen} + 4'd1));
          errO     <= badSeen || (rxCnt <= rdLen) || (ckByte != ~sumAcc);
        end
      end
    end
  end
endmodule

// File: rtl/regfrm_control.sv
module regfrm_control
  import regfrm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic       txBusyI,
  input  logic       lastByteI,
  input  logic       isWrI,
  input  logic       winDoneI,
  output ctlStrobe_t ctl,
  output logic       busyO
);
  ctlState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (startI) begin
        ctl.load  = 1'b1;
        nextState = ST_SEND;
      end
      ST_SEND: begin
        ctl.sendByte = 1'b1;
        nextState    = ST_WAITTX;
      end
      ST_WAITTX: if (!txBusyI) begin
        if (!lastByteI) begin
          nextState = ST_SEND;
        end else if (isWrI) begin
          nextState = ST_FIN;
        end else begin
          ctl.openWin = 1'b1;
          nextState   = ST_LISTEN;
        end
      end
      ST_LISTEN: if (winDoneI) nextState = ST_FIN;
      ST_FIN: begin
        ctl.finish = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busyO = (state != ST_IDLE);
endmodule

// File: rtl/regfrm_master.sv
module regfrm_master
  import regfrm_pkg::*;
#(
  parameter int CLKS_PER_BIT  = 1302,
  parameter int WINDOW_CYCLES = 150000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic        wrI,
  input  logic [6:0]  addrI,
  input  logic [15:0] wdataI,
  input  logic [2:0]  rdLenI,
  input  logic        rxI,
  output logic        txO,
  output logic        busyO,
  output logic        doneO,
  output logic [31:0] rdataO,
  output logic        errO,
  output logic        timeoutO,
  output logic        overrunO
);
  ctlStrobe_t ctl;
  logic txBusy, lastByte, winDone, isWr;

  regfrm_control ctrlU (
    .clk(clk), .rstN(rstN), .startI(startI), .txBusyI(txBusy),
    .lastByteI(lastByte), .isWrI(isWr), .winDoneI(winDone),
    .ctl(ctl), .busyO(busyO));

  regfrm_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) dpU (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrI(wrI), .addrI(addrI),
    .wdataI(wdataI), .rdLenI(rdLenI), .rxI(rxI), .txO(txO),
    .txBusyO(txBusy), .lastByteO(lastByte), .winDoneO(winDone),
    .isWrO(isWr), .rdataO(rdataO), .errO(errO), .timeoutO(timeoutO),
    .overrunO(overrunO), .doneO(doneO));
endmodule

// File: rtl/regfrm_master_chk.sv
module regfrm_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startI,
  input logic        txO,
  input logic        busyO,
  input logic        doneO,
  input logic [31:0] rdataO,
  input logic        errO,
  input logic        timeoutO,
  input logic        overrunO
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);  // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !busyO);  // R12
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !doneO |-> ($stable(rdataO) && $stable(errO) && $stable(timeoutO) && $stable(overrunO)));  // R12
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyO) |-> $past(startI));  // R11
  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busyO |-> txO);  // R5
  AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    timeoutO |-> (rdataO == 32'd0 && !errO && !overrunO));  // R8
  AST_OVERRUN_HAS_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    overrunO |-> !timeoutO);  // R9
endmodule

bind regfrm_master regfrm_master_chk chkU (
  .clk(clk), .rstN(rstN), .startI(startI), .txO(txO), .busyO(busyO),
  .doneO(doneO), .rdataO(rdataO), .errO(errO), .timeoutO(timeoutO),
  .overrunO(overrunO));

// File: tb/regfrm_master_tb.sv
module regfrm_master_tb_top;
  localparam int CPB = 8;
  localparam int WIN = 800;

  logic clk = 1'b0, rstN = 1'b0, startI = 1'b0, wrI = 1'b0, rxI = 1'b1;
  logic [6:0] addrI = '0;
  logic [15:0] wdataI = '0;
  logic [2:0] rdLenI = 3'd2;
  logic txO, busyO, doneO, errO, timeoutO, overrunO;
  logic [31:0] rdataO;

  int nChk = 0, nFail = 0, capCnt = 0, fmtBad = 0, nResp = 0, flipIdx = -1;
  longint cycNow = 0;
  bit allDone = 0;
  logic [7:0] capB [0:15];
  logic [7:0] resp [0:7];

  always #10 clk = ~clk;
  always @(posedge clk) cycNow <= cycNow + 1;

  regfrm_master #(.CLKS_PER_BIT(CPB), .WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .wrI(wrI), .addrI(addrI),
    .wdataI(wdataI), .rdLenI(rdLenI), .rxI(rxI), .txO(txO), .busyO(busyO),
    .doneO(doneO), .rdataO(rdataO), .errO(errO), .timeoutO(timeoutO),
    .overrunO(overrunO));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // decode request bytes from txO at mid-bit (R5)
  always begin
    logic [7:0] b;
    logic st, pb, sp;
    @(negedge clk);
    if (rstN && txO === 1'b0) begin
      repeat (CPB / 2) @(negedge clk);
      st = txO;
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        b[i] = txO;
      end
      repeat (CPB) @(negedge clk);
      pb = txO;
      repeat (CPB) @(negedge clk);
      sp = txO;
      if (st !== 1'b0 || pb !== ^b || sp !== 1'b1) fmtBad++;
      if (capCnt < 16) capB[capCnt] = b;
      capCnt++;
    end
  end

  task automatic sendRx(input logic [7:0] b, input bit flipPar);
    logic [10:0] f;
    f = {1'b1, (^b) ^ flipPar, b, 1'b0};
    for (int k = 0; k < 11; k++) begin
      rxI = f[k];
      repeat (CPB) @(negedge clk);
    end
  endtask

  function automatic int effLenTb(input logic [2:0] l);
    return (l == 3'd2 || l == 3'd3) ? int'(l) : 4;
  endfunction

  // well-formed response: data bytes plus checksum, optional extra bytes
  task automatic mkResp(input logic [6:0] addr, input logic [2:0] lenIn, input int extra);
    int n;
    logic [7:0] s;
    n = effLenTb(lenIn);
    s = 8'hA5 + {1'b0, addr};
    for (int k = 0; k < n; k++) begin
      resp[k] = 8'($urandom);
      s = s + resp[k];
    end
    resp[n] = ~s;
    for (int k = n + 1; k < 8; k++) resp[k] = 8'($urandom);
    nResp = n + 1 + extra;
    flipIdx = -1;
  endtask

  task automatic runTxn(input bit wr, input logic [6:0] addr, input logic [15:0] wd,
                        input logic [2:0] lenIn, input bit poke);
    logic [7:0] expB [0:7];
    logic [7:0] s;
    logic [31:0] eData;
    bit eTo, eErr, eOvr;
    int nExp, lenE, dueCyc;
    longint mark, got;
    lenE = effLenTb(lenIn);
    expB[0] = 8'hA5;
    expB[1] = {wr, addr};
    nExp = 2;
    if (wr) begin
      if (wd < 16'h00FF) begin
        expB[2] = wd[7:0]; nExp = 3;
      end else begin
        expB[2] = wd[15:8]; expB[3] = wd[7:0]; nExp = 4;
      end
      s = 8'h00;
      for (int k = 0; k < nExp; k++) s = s + expB[k];
      expB[nExp] = ~s;
      nExp++;
    end
    @(negedge clk);
    wrI = wr; addrI = addr; wdataI = wd; rdLenI = lenIn; startI = 1'b1;
    capCnt = 0; fmtBad = 0; mark = cycNow;
    @(negedge clk);
    startI = 1'b0;
    if (poke) begin
      while (capCnt < 1) @(negedge clk);
      addrI = addr ^ 7'h55; wrI = !wr; wdataI = ~wd; startI = 1'b1;
      @(negedge clk);
      startI = 1'b0;
    end
    if (!wr) begin
      while (capCnt < 2) @(negedge clk);
      repeat (CPB) @(negedge clk);
      for (int k = 0; k < nResp; k++) sendRx(resp[k], k == flipIdx);
    end
    while (!doneO) @(negedge clk);
    got = cycNow - mark;
    dueCyc = wr ? nExp * (11 * CPB + 2) + 2 : 2 * (11 * CPB + 2) + WIN + 2;
    chk(got == dueCyc, wr ? "R12 write done cycle" : "R8 read window done cycle", got, dueCyc);
    chk(capCnt == nExp, wr ? "R3 write frame length" : "R1 read request length", capCnt, nExp);
    chk(fmtBad == 0, "R5 serial byte format", fmtBad, 0);
    for (int k = 0; k < nExp && k < capCnt; k++)
      chk(capB[k] == expB[k],
          (k == 0) ? "R1 header byte" : (k == 1) ? "R2 address byte" :
          (wr && k == nExp - 1) ? "R4 write checksum" : "R3 data byte", capB[k], expB[k]);
    if (wr) begin
      chk(rdataO == 0 && !errO && !timeoutO && !overrunO, "R12 write clears results",
          {rdataO, errO, timeoutO, overrunO}, 0);
    end else begin
      eTo = (nResp == 0);
      eData = 0;
      s = 8'hA5 + {1'b0, addr};
      for (int k = 0; k < nResp && k < lenE; k++) begin
        eData = {eData[23:0], resp[k]};
        s = s + resp[k];
      end
      eOvr = (nResp > lenE + 1);
      eErr = !eTo && ((flipIdx >= 0 && flipIdx < nResp) || nResp < lenE + 1 || resp[lenE] != ~s);
      chk(rdataO == eData, "R6 R7 read data", rdataO, eData);
      chk(errO == eErr, "R6 R10 error flag", errO, eErr);
      chk(timeoutO == eTo, "R8 timeout flag", timeoutO, eTo);
      chk(overrunO == eOvr, "R9 overrun flag", overrunO, eOvr);
    end
    @(negedge clk);
    chk(doneO == 1'b0, "R12 done one cycle", doneO, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(capCnt == nExp && !busyO, "R11 start while busy ignored", capCnt, nExp);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txO == 1'b1 && !busyO && !doneO, "R5 R12 reset idle", {txO, busyO, doneO}, 3'b100);
    chk(rdataO == 0 && !errO && !timeoutO && !overrunO, "R12 reset results",
        {rdataO, errO, timeoutO, overrunO}, 0);

    runTxn(1'b1, 7'h13, 16'h00FE, 3'd2, 1'b0);   // R3 single byte
    runTxn(1'b1, 7'h00, 16'h00FF, 3'd2, 1'b0);   // R3 boundary: two bytes
    runTxn(1'b1, 7'h01, 16'h0000, 3'd2, 1'b0);   // R3 zero value
    runTxn(1'b1, 7'h6A, 16'hBEEF, 3'd2, 1'b1);   // R11 start while busy
    mkResp(7'h26, 3'd2, 0); runTxn(1'b0, 7'h26, 16'h0, 3'd2, 1'b0);   // R6
    mkResp(7'h2C, 3'd4, 0); runTxn(1'b0, 7'h2C, 16'h0, 3'd4, 1'b0);   // R6
    mkResp(7'h24, 3'd0, 0); runTxn(1'b0, 7'h24, 16'h0, 3'd0, 1'b0);   // R7 code 0 -> 4
    mkResp(7'h25, 3'd7, 0); runTxn(1'b0, 7'h25, 16'h0, 3'd7, 1'b0);   // R7 code 7 -> 4
    nResp = 0; flipIdx = -1; runTxn(1'b0, 7'h43, 16'h0, 3'd3, 1'b0); // R8 timeout
    mkResp(7'h70, 3'd3, 0); resp[3] = resp[3] ^ 8'h01;
    runTxn(1'b0, 7'h70, 16'h0, 3'd3, 1'b0);                          // R6 bad checksum
    mkResp(7'h71, 3'd2, 0); flipIdx = 1;
    runTxn(1'b0, 7'h71, 16'h0, 3'd2, 1'b0);                          // R10 parity
    mkResp(7'h72, 3'd3, 0); nResp = 2;
    runTxn(1'b0, 7'h72, 16'h0, 3'd3, 1'b0);                          // R10 short
    mkResp(7'h23, 3'd2, 1); runTxn(1'b0, 7'h23, 16'h0, 3'd2, 1'b0);   // R9 overrun
    mkResp(7'h23, 3'd4, 1); runTxn(1'b0, 7'h23, 16'h0, 3'd4, 1'b0);   // R9 overrun

    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic [15:0] w;
      logic [2:0] l;
      a = 7'($urandom);
      w = ($urandom % 3 == 0) ? 16'($urandom % 255) : 16'($urandom);
      l = 3'(2 + $urandom % 3);
      if ($urandom % 2 == 1) begin
        runTxn(1'b1, a, w, l, 1'b0);
      end else begin
        mkResp(a, l, 0);
        runTxn(1'b0, a, w, l, 1'b0);
      end
    end

    allDone = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!allDone) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycNow, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule